// File: doc/BRIEF.md
# Batched Event Interrupt Counter

This block turns a fast stream of event pulses into a slow stream of interrupt requests. Two pulse sources reach it asynchronously to the system clock: level-1 trigger accepts and readout-error flags. Software picks one of them, and each rising edge of the selected source adds one to a pending-event count. When the count reaches a programmable threshold, the block raises an interrupt. The handler then acknowledges, and each acknowledge removes one batch of threshold size from the count. A host whose interrupt service rate is far below the event rate can therefore handle events in large groups.

Software can pause the counter to read a stable value. While the pause is set, the count does not change. Events that arrive in that time go into a small side accumulator and are added when the pause is released. The count saturates at its full-scale value and sets a sticky overflow flag. The count, the flag and the interrupt appear directly on output ports.

Top module: `batch_evt_irq`

## Requirements
- R1: After reset (active-low, synchronous), the count, interrupt and overflow flag are 0, the threshold is 0 and all control bits are 0.
- R2: Each event pulse passes through a two-flop synchronizer and a rising-edge detector. Each low-to-high transition of the selected input adds exactly 1 to the count, however long the input then stays high.
- R3: Control register (address 1) bit 1 selects the source: 0 counts `l1_evt`, 1 counts `rerr_evt`. The other input has no effect on the count.
- R4: Control bit 0 is the enable. While it is 0, events on either input are not counted.
- R5: The interrupt is registered. It is high when the threshold (address 0) is non-zero and the count is greater than or equal to the threshold. It updates on the same edge as the count.
- R6: A write to address 2 is an acknowledge. It subtracts the threshold from the count, with a floor of 0. The interrupt is low in the cycle after the acknowledge, and it rises again one cycle later if the count is still at or above the threshold.
- R7: Control bit 2 is the pause. While it is set, the count holds and acknowledges are ignored. Events are kept in a pending accumulator, and all of them are added on the first cycle after the pause is cleared.
- R8: If an event and an acknowledge take effect in the same cycle, both are applied. The count becomes count + 1 - threshold.
- R9: The count saturates at 2^CNT_W-1 (255 by default) and sets a sticky overflow flag. The flag is cleared only by writing to address 3 with data bit 0 = 1. Such a write with bit 0 = 0 leaves the flag unchanged.
- R10: A threshold of 0 keeps the interrupt low whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l1_evt | input | 1 | Asynchronous level-1 accept pulse |
| rerr_evt | input | 1 | Asynchronous readout-error pulse |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 threshold, 1 control, 2 acknowledge, 3 overflow clear |
| cfg_wdata | input | CNT_W | Register write data |
| count_o | output | CNT_W | Current pending-event count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The count is driven with short pulses and with pulses held high for many cycles. This separates true edge detection from counting levels. Pulses go to both the selected and the unselected input, and also while the block is disabled, to show that the source mux and the enable gate events. An acknowledge is placed on the exact cycle an event takes effect, which exposes a design that lets one update win over the other. Pause-with-burst and saturation runs show whether events are kept or lost, and whether the overflow flag is sticky.

// File: rtl/evtirq_pkg.sv
// Shared definitions for the batched event interrupt counter.
// Assumes a 2-bit register address and control bits in the low three data bits.
package evtirq_pkg;
    typedef enum logic [1:0] {
        ADDR_THR    = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_ACK    = 2'd2,
        ADDR_OVFCLR = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic pause;
        logic src;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/evtirq_sync.sv
// Brings one asynchronous pulse into the clock domain and emits a
// single-cycle pulse on each rising edge. Assumes input pulses last at
// least two clock periods so that the synchronizer captures them.
module evtirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [STAGES:0] sh_q;

    // Shift chain: STAGES synchronizer flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    // Rising edge of the synchronized level.
    assign pulse = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/evtirq_regs.sv
// Register port: stores threshold and control, and decodes the
// acknowledge and overflow-clear strobes. Write-only; status is on ports.
module evtirq_regs
    import evtirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] thr,
    output ctrl_t            ctrl,
    output logic             ack_hit,
    output logic             ovf_clr
);
    // Threshold and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr  <= '0;
            ctrl <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == ADDR_THR)  thr  <= cfg_wdata;
            if (cfg_addr == ADDR_CTRL) ctrl <= ctrl_t'(cfg_wdata[2:0]);
        end
    end

    // Single-cycle strobes decoded from the write.
    assign ack_hit = cfg_wr && (cfg_addr == ADDR_ACK);
    assign ovf_clr = cfg_wr && (cfg_addr == ADDR_OVFCLR) && cfg_wdata[0];
endmodule

// File: rtl/evtirq_pend.sv
// Pending accumulator: holds events that arrive while paused. It empties
// in the first unpaused cycle, when the core consumes its value.
// Saturates at its full scale.
module evtirq_pend #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pause,
    input  logic              evt_ok,
    output logic [PEND_W-1:0] pend
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    // Collect while paused, drop to zero once the value has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || !pause)                pend <= '0;
        else if (evt_ok && pend != PEND_MAX) pend <= pend + 1'b1;
    end
endmodule

// File: rtl/evtirq_core.sv
// Up/down counter with saturation, sticky overflow and a registered
// interrupt. Assumes ack and ovf_clr are single-cycle strobes.
module evtirq_core #(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_ok,
    input  logic              pause,
    input  logic              ack,
    input  logic              ovf_clr,
    input  logic [CNT_W-1:0]  thr,
    input  logic [PEND_W-1:0] pend,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic              irq_o
);
    localparam int SW = CNT_W + PEND_W + 1;
    localparam logic [SW-1:0] CNT_MAX = SW'({CNT_W{1'b1}});

    logic [SW-1:0]    sum, dec, diff;
    logic [CNT_W-1:0] cnt_nxt;
    logic             ovf_set, ack_live;

    // Net update: increments plus released backlog minus one serviced batch.
    always_comb begin
        ack_live = ack && !pause;
        sum      = SW'(count_o) + (pause ? '0 : (SW'(evt_ok) + SW'(pend)));
        dec      = ack_live ? SW'(thr) : '0;
        diff     = (sum >= dec) ? (sum - dec) : '0;
        ovf_set  = diff > CNT_MAX;
        cnt_nxt  = ovf_set ? CNT_MAX[CNT_W-1:0] : diff[CNT_W-1:0];
    end

    // Count, overflow and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            count_o <= cnt_nxt;
            if (ovf_set)      ovf_o <= 1'b1;
            else if (ovf_clr) ovf_o <= 1'b0;
            irq_o <= (thr != '0) && (cnt_nxt >= thr) && !ack_live;
        end
    end
endmodule

// File: rtl/batch_evt_irq.sv
// Top level: batches asynchronous event pulses into threshold-sized
// interrupts. One synchronizer per source, a register port, a pause
// backlog and the counting core.
module batch_evt_irq
    import evtirq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PEND_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1_evt,
    input  logic             rerr_evt,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             irq_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0]   src_in, src_pulse;
    logic [CNT_W-1:0]  thr;
    ctrl_t             ctrl;
    logic              ack_hit, ovf_clr, evt_ok;
    logic [PEND_W-1:0] pend;

    assign src_in = {rerr_evt, l1_evt};

    // One synchronizer and edge detector per event source.
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        evtirq_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk(clk), .rst_n(rst_n), .din(src_in[g]), .pulse(src_pulse[g])
        );
    end

    // Selected and enabled event for this cycle.
    assign evt_ok = ctrl.en && src_pulse[ctrl.src];

    evtirq_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .thr(thr), .ctrl(ctrl),
        .ack_hit(ack_hit), .ovf_clr(ovf_clr)
    );

    evtirq_pend #(.PEND_W(PEND_W)) i_pend (
        .clk(clk), .rst_n(rst_n), .pause(ctrl.pause), .evt_ok(evt_ok), .pend(pend)
    );

    evtirq_core #(.CNT_W(CNT_W), .PEND_W(PEND_W)) i_core (
        .clk(clk), .rst_n(rst_n), .evt_ok(evt_ok), .pause(ctrl.pause),
        .ack(ack_hit), .ovf_clr(ovf_clr), .thr(thr), .pend(pend),
        .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/evtirq_chk.sv
// Property checker for batch_evt_irq, attached by bind.
module evtirq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             paused,
    input logic             ack_hit,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] thr,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> $stable(count_o)); // R7
    AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |=> !irq_o); // R10
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !paused) |=> !irq_o); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr) |=> ovf_o); // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CMAX && !ack_hit) |=> (count_o == CMAX)); // R9
endmodule

bind batch_evt_irq evtirq_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .paused(ctrl.pause), .ack_hit(ack_hit),
    .ovf_clr(ovf_clr), .thr(thr), .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o)
);

// File: tb/test_batch_evt_irq.sv
`timescale 1ns/1ps
module test_batch_evt_irq;
    logic       clk = 0, rst_n = 0;
    logic       l1_evt = 0, rerr_evt = 0, cfg_wr = 0;
    logic [1:0] cfg_addr = 0;
    logic [7:0] cfg_wdata = 0, count_o;
    logic       ovf_o, irq_o;

    int total = 0, bad = 0;
    int m_cnt = 0, m_thr = 0;
    bit m_ovf = 0;
    string tq[$];
    int    cq[$];
    bit    iq[$], oq[$];

    always #4 clk = ~clk;

    batch_evt_irq i_batch_evt_irq (
        .clk(clk), .rst_n(rst_n), .l1_evt(l1_evt), .rerr_evt(rerr_evt),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side: push the model's expected outputs.
    task automatic expect_now(string tag);
        tq.push_back(tag);
        cq.push_back(m_cnt);
        iq.push_back(m_thr != 0 && m_cnt >= m_thr);
        oq.push_back(m_ovf);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop and compare away from the active edge.
    initial forever begin
        @(negedge clk);
        while (tq.size() > 0) begin
            string t;
            t = tq.pop_front();
            chk({t, " count"}, count_o, cq.pop_front());
            chk({t, " irq"}, irq_o, iq.pop_front());
            chk({t, " ovf"}, ovf_o, oq.pop_front());
        end
    end

    task automatic wr(logic [1:0] a, int d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d[7:0];
        @(negedge clk);
        cfg_wr = 0;
    endtask

    function automatic void m_inc();
        if (m_cnt == 255) m_ovf = 1; else m_cnt++;
    endfunction

    function automatic void m_ack();
        m_cnt = (m_cnt >= m_thr) ? m_cnt - m_thr : 0;
    endfunction

    // One pulse on a source; hold = cycles the input stays high.
    task automatic pulse(bit rerr, int hold);
        @(negedge clk);
        if (rerr) rerr_evt = 1; else l1_evt = 1;
        repeat (hold) @(negedge clk);
        rerr_evt = 0; l1_evt = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        expect_now("R1 reset");

        wr(1, 1); wr(0, 3); m_thr = 3;
        pulse(0, 2); m_inc(); pulse(0, 2); m_inc();
        expect_now("R2 short pulses");
        pulse(0, 12); m_inc();
        expect_now("R2 long pulse counts once, R5 irq");

        pulse(1, 2);
        expect_now("R3 unselected rerr ignored");

        wr(2, 0); m_ack();
        chk("R6 irq low after ack", irq_o, 0);
        expect_now("R6 ack to zero");

        for (int i = 0; i < 7; i++) begin pulse(0, 2); m_inc(); end
        expect_now("R5 count above threshold");
        wr(2, 0); m_ack();
        chk("R6 irq dropped", irq_o, 0);
        @(negedge clk);
        chk("R6 irq reasserts", irq_o, 1);
        expect_now("R6 ack leaves 4");
        wr(2, 0); m_ack();
        wr(2, 0); m_ack();
        expect_now("R6 ack floors at zero");

        wr(1, 3);
        pulse(1, 2); m_inc(); pulse(1, 2); m_inc();
        pulse(0, 2);
        expect_now("R3 rerr selected, l1 ignored");

        wr(1, 2);
        pulse(1, 2); pulse(0, 2);
        expect_now("R4 disabled ignores events");

        wr(1, 7);
        pulse(1, 2); pulse(1, 2); pulse(1, 2);
        expect_now("R7 paused count holds");
        wr(2, 0);
        expect_now("R7 ack ignored while paused");
        wr(1, 3); m_inc(); m_inc(); m_inc();
        expect_now("R7 backlog applied on release");

        // R8: event pulse and acknowledge land on the same edge.
        @(negedge clk); rerr_evt = 1;
        @(negedge clk);
        @(negedge clk); cfg_wr = 1; cfg_addr = 2; cfg_wdata = 0;
        @(negedge clk); cfg_wr = 0; rerr_evt = 0;
        m_inc(); m_ack();
        chk("R8 irq low after combined update", irq_o, 0);
        repeat (3) @(negedge clk);
        expect_now("R8 net change applied");

        wr(0, 0); m_thr = 0;
        @(negedge clk);
        pulse(1, 2); m_inc();
        expect_now("R10 zero threshold no irq");

        while (m_cnt < 255) begin pulse(1, 2); m_inc(); end
        expect_now("R9 reaches full scale");
        pulse(1, 2); m_inc();
        expect_now("R9 saturate sets overflow");
        wr(3, 0);
        expect_now("R9 clear with bit0=0 keeps flag");
        wr(3, 1); m_ovf = 0;
        expect_now("R9 overflow cleared");

        wr(0, 200); m_thr = 200;
        @(negedge clk);
        expect_now("R5 irq from new threshold");
        wr(2, 0); m_ack();
        expect_now("R6 ack from full scale");

        while (tq.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule